// File: doc/BRIEF.md
# Serial-Controlled SAR Converter Sequencer

This block is the digital sequencer of an 8-bit successive-approximation converter that a host drives over a three-wire serial link: an active-low select, the serial clock (which is the block's clock) and a data-in line, with a data-out line that carries an output-enable. The host lowers select and then sends a start bit followed by a two-bit input assignment. The block decodes that assignment into multiplexer controls, spends one clock settling while data-out drives low, and then runs an 8-step binary search. On each step it offers a trial code to an external DAC and reads back one comparator bit.

Every decided bit goes out on data-out as soon as it is resolved, most significant first. The stored result then goes out a second time, least significant first, and the shared bit 0 is not repeated. Raising select at any time aborts the transaction and clears all state. Data-in is only looked at during addressing, so data-in and data-out may share one bidirectional host pin.

Top module: `sar_serial_seq`

## Requirements
- R1: While `rst` is high or `cs_n` is high, the next clock edge clears all state: `do_en`=0, `do_bit`=0, `trial_code`=0, `mux_pos_ch1`=0 and `mux_neg`=00.
- R2: With `cs_n` low and no transaction under way, edges that sample `di`=0 are idle and do not advance anything. The first edge that samples `di`=1 takes it as the start bit.
- R3: The two edges that follow the start bit sample the mode bit (1 = single-ended, 0 = differential) and then the odd bit. From then on the outputs hold the decode. `mux_pos_ch1`=1 means CH1 is the positive input and 0 means CH0 is. `mux_neg` is 00 for ground, 01 for CH0 and 10 for CH1. Single-ended gives pos = odd and neg = 00. Differential with odd=0 gives pos CH0 and neg 10. Differential with odd=1 gives pos CH1 and neg 01.
- R4: The edge that samples the odd bit sets `do_en`=1 with `do_bit`=0. DO then stays low for exactly one clock period, which is the settling period.
- R5: During each search cycle for bit k, `trial_code` holds the bits already decided above k, has bit k set, and has all lower bits clear. A bit is kept when `cmp_ge`=1 (input ≥ trial) and cleared otherwise.
- R6: The search takes 8 clock periods. Each decision, from bit 7 down to bit 0, appears on `do_bit` right after the edge that makes it.
- R7: After bit 0, `do_bit` gives bits 1 through 7 of the result, one per clock. Bit 0 is not sent twice.
- R8: `di` has no effect from the end of addressing until `cs_n` rises.
- R9: After the last bit of the LSB-first stream, `do_bit` and `do_en` hold their values and `trial_code` stays 0, however many more clocks arrive.
- R10: If the comparator never reports ≥, for example because the negative input exceeds the positive one, the result is all zeros and every data bit on DO is low.
- R11: Raising `cs_n` partway through a search aborts it. A new transaction after that completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select; high clears all state |
| di | input | 1 | Serial data in (start bit and assignment) |
| cmp_ge | input | 1 | Comparator: selected input ≥ trial code |
| trial_code | output | RES_W | Trial code to the external DAC |
| mux_pos_ch1 | output | 1 | Positive input: 1 = CH1, 0 = CH0 |
| mux_neg | output | 2 | Negative input: 00 ground, 01 CH0, 10 CH1 |
| do_bit | output | 1 | Serial data out value |
| do_en | output | 1 | Data-out drive enable (0 = high impedance) |

## Verification
The bench targets the points where the two output streams join and where they end. A design that repeated bit 0 or dropped the final replayed bit would shift every later DO bit out of place. A design with no hold state would keep shifting after the stream ends. The bench toggles `di` throughout conversion and replay, which catches a sequencer that restarts or re-samples the assignment after addressing. It also aborts a transaction mid-search with `di` held high, which catches state left behind by an incomplete clear or a start bit taken while select is high. Finally, it covers the differential case where the negative input is larger, and the full-scale and zero codes, to expose off-by-one keep or clear decisions in the search.

// File: rtl/sarseq_pkg.sv
package sarseq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SGL,
        PH_ODD,
        PH_CONV,
        PH_REPLAY,
        PH_HOLD
    } phase_t;

    typedef enum logic [1:0] {
        NEG_GND = 2'b00,
        NEG_CH0 = 2'b01,
        NEG_CH1 = 2'b10
    } neg_src_t;

    typedef struct packed {
        logic     pos_ch1;
        neg_src_t neg;
    } mux_sel_t;

    localparam mux_sel_t MUX_RESET = '{pos_ch1: 1'b0, neg: NEG_GND};

    // Turn the mode bit and the odd bit into multiplexer controls.
    function automatic mux_sel_t decode_assign(input logic single, input logic odd);
        mux_sel_t m;
        if (single) begin
            m.pos_ch1 = odd;
            m.neg     = NEG_GND;
        end else if (!odd) begin
            m.pos_ch1 = 1'b0;
            m.neg     = NEG_CH1;
        end else begin
            m.pos_ch1 = 1'b1;
            m.neg     = NEG_CH0;
        end
        return m;
    endfunction

endpackage

// File: rtl/sarseq_ctrl.sv
module sarseq_ctrl
    import sarseq_pkg::*;
#(
    parameter int RES_W = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cs_n,
    input  logic                         di,
    output phase_t                       phase,
    output logic [$clog2(RES_W)-1:0]     cnt,
    output mux_sel_t                     mux
);
    localparam int CNT_W = $clog2(RES_W);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(RES_W - 1);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic clr;
    logic sgl_q;

    assign clr = rst | cs_n;

    always_ff @(posedge clk) begin
        if (clr) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            sgl_q <= 1'b0;
            mux   <= MUX_RESET;
        end else begin
            unique case (phase)
                PH_IDLE:   if (di) phase <= PH_SGL;
                PH_SGL: begin
                    sgl_q <= di;
                    phase <= PH_ODD;
                end
                PH_ODD: begin
                    mux   <= decode_assign(sgl_q, di);
                    cnt   <= CNT_TOP;
                    phase <= PH_CONV;
                end
                PH_CONV: begin
                    if (cnt == '0) begin
                        cnt   <= CNT_ONE;
                        phase <= PH_REPLAY;
                    end else begin
                        cnt <= cnt - CNT_ONE;
                    end
                end
                PH_REPLAY: begin
                    if (cnt == CNT_TOP) phase <= PH_HOLD;
                    else                cnt   <= cnt + CNT_ONE;
                end
                PH_HOLD:   phase <= PH_HOLD;
                default:   phase <= PH_IDLE;
            endcase
        end
    end

    // R2: a low di while idle keeps the sequencer idle
    a_r2_idle_wait: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && !cs_n && !di) |=> phase == PH_IDLE);

    // R3, R8: the decoded assignment holds through the search
    a_r3_mux_held: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_CONV && !cs_n) |=> $stable(mux));

    // R9: the end state is sticky while selected
    a_r9_hold_sticky: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HOLD && !cs_n) |=> phase == PH_HOLD);

endmodule

// File: rtl/sarseq_search.sv
module sarseq_search
    import sarseq_pkg::*;
#(
    parameter int RES_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cs_n,
    input  phase_t                   phase,
    input  logic [$clog2(RES_W)-1:0] cnt,
    input  logic                     cmp_ge,
    output logic [RES_W-1:0]         trial_code,
    output logic [RES_W-1:0]         result
);
    logic [RES_W-1:0] probe;

    always_comb begin
        probe      = '0;
        probe[cnt] = 1'b1;
        trial_code = (phase == PH_CONV) ? (result | probe) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst || cs_n) begin
            result <= '0;
        end else if (phase == PH_CONV) begin
            result[cnt] <= cmp_ge;
        end
    end

    // R5: each step keeps one trial bit when the comparator reports >=
    a_r5_trial_count: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_CONV && cnt != '0 && !cs_n) |=>
            $countones(trial_code) == $countones($past(trial_code)) + int'($past(cmp_ge)));

endmodule

// File: rtl/sarseq_dout.sv
module sarseq_dout
    import sarseq_pkg::*;
#(
    parameter int RES_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cs_n,
    input  phase_t                   phase,
    input  logic [$clog2(RES_W)-1:0] cnt,
    input  logic                     cmp_ge,
    input  logic [RES_W-1:0]         result,
    output logic                     do_bit,
    output logic                     do_en
);
    always_ff @(posedge clk) begin
        if (rst || cs_n) begin
            do_bit <= 1'b0;
            do_en  <= 1'b0;
        end else begin
            unique case (phase)
                PH_ODD: begin
                    do_en  <= 1'b1;
                    do_bit <= 1'b0;
                end
                PH_CONV:   do_bit <= cmp_ge;
                PH_REPLAY: do_bit <= result[cnt];
                default:   do_bit <= do_bit;
            endcase
        end
    end

    // R4: data out stays released until the assignment is complete
    a_r4_quiet_addr: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE || phase == PH_SGL || phase == PH_ODD) |-> !do_en);

endmodule

// File: rtl/sar_serial_seq.sv
module sar_serial_seq
    import sarseq_pkg::*;
#(
    parameter int RES_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             di,
    input  logic             cmp_ge,
    output logic [RES_W-1:0] trial_code,
    output logic             mux_pos_ch1,
    output logic [1:0]       mux_neg,
    output logic             do_bit,
    output logic             do_en
);
    localparam int CNT_W = $clog2(RES_W);

    phase_t           phase;
    logic [CNT_W-1:0] cnt;
    mux_sel_t         mux;
    logic [RES_W-1:0] result;

    sarseq_ctrl #(.RES_W(RES_W)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .cs_n  (cs_n),
        .di    (di),
        .phase (phase),
        .cnt   (cnt),
        .mux   (mux)
    );

    sarseq_search #(.RES_W(RES_W)) u_search (
        .clk        (clk),
        .rst        (rst),
        .cs_n       (cs_n),
        .phase      (phase),
        .cnt        (cnt),
        .cmp_ge     (cmp_ge),
        .trial_code (trial_code),
        .result     (result)
    );

    sarseq_dout #(.RES_W(RES_W)) u_dout (
        .clk    (clk),
        .rst    (rst),
        .cs_n   (cs_n),
        .phase  (phase),
        .cnt    (cnt),
        .cmp_ge (cmp_ge),
        .result (result),
        .do_bit (do_bit),
        .do_en  (do_en)
    );

    assign mux_pos_ch1 = mux.pos_ch1;
    assign mux_neg     = mux.neg;

    // R1: a high select empties every output on the next edge
    a_r1_clear: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> (!do_en && !do_bit && trial_code == '0 && mux_neg == 2'b00 && !mux_pos_ch1));

    // R6: every search decision reaches data out one edge later
    a_r6_decision_out: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_CONV && !cs_n) |=> (do_en && do_bit == $past(cmp_ge)));

    // R3: the negative-input select never names two sources at once
    a_r3_neg_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(mux_neg));

    // R9: after the stream ends data out is frozen and driven
    a_r9_frozen: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HOLD && !cs_n) |=> ($stable(do_bit) && do_en && trial_code == '0));

endmodule

// File: tb/sar_serial_seq_tb.sv
`timescale 1ns/1ps
module sar_serial_seq_tb;
    localparam int RES_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cs_n = 1'b1;
    logic             di = 1'b0;
    logic             cmp_ge;
    logic [RES_W-1:0] trial_code;
    logic             mux_pos_ch1;
    logic [1:0]       mux_neg;
    logic             do_bit;
    logic             do_en;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Behavioural analog side: two channel levels as codes
    int a_ch0 = 0;
    int a_ch1 = 0;

    always #2 clk = ~clk;

    sar_serial_seq #(.RES_W(RES_W)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .cs_n        (cs_n),
        .di          (di),
        .cmp_ge      (cmp_ge),
        .trial_code  (trial_code),
        .mux_pos_ch1 (mux_pos_ch1),
        .mux_neg     (mux_neg),
        .do_bit      (do_bit),
        .do_en       (do_en)
    );

    always_comb begin
        int pv;
        int nv;
        pv = mux_pos_ch1 ? a_ch1 : a_ch0;
        case (mux_neg)
            2'b01:   nv = a_ch0;
            2'b10:   nv = a_ch1;
            default: nv = 0;
        endcase
        cmp_ge = (pv - nv) >= int'(trial_code);
    end

    // {single, odd, ch0, ch1}
    localparam logic [17:0] VEC [0:6] = '{
        {1'b1, 1'b0, 8'd200, 8'd17},
        {1'b1, 1'b1, 8'd55,  8'd170},
        {1'b0, 1'b0, 8'd180, 8'd60},
        {1'b0, 1'b1, 8'd30,  8'd255},
        {1'b0, 1'b0, 8'd10,  8'd90},
        {1'b1, 1'b0, 8'd255, 8'd0},
        {1'b1, 1'b1, 8'd7,   8'd0}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int expect_code(input bit sgl, input bit odd, input int c0, input int c1);
        int v;
        if (sgl)       v = odd ? c1 : c0;
        else if (!odd) v = c0 - c1;
        else           v = c1 - c0;
        return (v < 0) ? 0 : v;
    endfunction

    task automatic run_txn(input bit sgl, input bit odd, input int c0, input int c1, input bit wiggle);
        int e;
        int ep;
        int en;
        int tr;
        e  = expect_code(sgl, odd, c0, c1);
        ep = sgl ? int'(odd) : int'(odd);
        en = sgl ? 0 : (odd ? 1 : 2);
        a_ch0 = c0;
        a_ch1 = c1;
        cs_n = 1'b0;
        di   = 1'b0;
        repeat (3) @(negedge clk);
        chk(!do_en, "R2 idle low di leaves DO released", int'(do_en), 0);
        di = 1'b1;
        @(negedge clk);
        di = sgl;
        @(negedge clk);
        di = odd;
        @(negedge clk);
        chk(do_en && !do_bit, "R4 leading low after addressing", int'(do_bit), 0);
        chk(mux_pos_ch1 == ep[0], "R3 positive select", int'(mux_pos_ch1), ep);
        chk(int'(mux_neg) == en, "R3 negative select", int'(mux_neg), en);
        for (int k = RES_W - 1; k >= 0; k--) begin
            tr = ((e >> (k + 1)) << (k + 1)) | (1 << k);
            chk(int'(trial_code) == tr, "R5 trial code", int'(trial_code), tr);
            if (wiggle) di = k[0];
            @(negedge clk);
            chk(do_bit == e[k], wiggle ? "R8 MSB-first bit with di toggling" : "R6 MSB-first bit",
                int'(do_bit), e[k]);
        end
        for (int k = 1; k < RES_W; k++) begin
            if (wiggle) di = ~k[0];
            @(negedge clk);
            chk(do_bit == e[k], "R7 LSB-first bit", int'(do_bit), e[k]);
        end
        for (int k = 0; k < 3; k++) begin
            if (wiggle) di = k[0];
            @(negedge clk);
            chk(do_en && do_bit == e[RES_W-1] && trial_code == '0, "R9 hold after stream",
                int'(do_bit), e[RES_W-1]);
        end
        if (e == 0) chk(do_bit == 1'b0, "R10 all-zero result", int'(do_bit), 0);
        cs_n = 1'b1;
        di   = 1'b0;
        @(negedge clk);
        chk(!do_en && !mux_pos_ch1 && mux_neg == 2'b00, "R1 select high clears",
            int'(do_en), 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!do_en && trial_code == '0 && mux_neg == 2'b00 && !mux_pos_ch1,
            "R1 reset state", int'(do_en), 0);
        rst = 1'b0;
        @(negedge clk);

        foreach (VEC[i]) begin
            run_txn(VEC[i][17], VEC[i][16], int'(VEC[i][15:8]), int'(VEC[i][7:0]), i[0]);
        end

        // R2: long idle with select low and di low
        cs_n = 1'b0;
        di   = 1'b0;
        repeat (6) @(negedge clk);
        chk(!do_en && trial_code == '0, "R2 no start without high di", int'(do_en), 0);
        cs_n = 1'b1;
        @(negedge clk);

        // R11: abort partway through a search
        a_ch0 = 200;
        a_ch1 = 0;
        cs_n = 1'b0;
        di = 1'b1;
        @(negedge clk);
        di = 1'b1;
        @(negedge clk);
        di = 1'b0;
        @(negedge clk);
        repeat (3) @(negedge clk);
        chk(do_en, "R11 search under way before abort", int'(do_en), 1);
        cs_n = 1'b1;
        di   = 1'b1;
        @(negedge clk);
        chk(!do_en && trial_code == '0, "R11 abort clears", int'(trial_code), 0);
        @(negedge clk);
        chk(!do_en && trial_code == '0, "R11 no start while select high", int'(do_en), 0);
        run_txn(1'b0, 1'b1, 40, 141, 1'b0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule